// File: doc/BRIEF.md
# Complement-Deficit Decimal Divider

This block divides a packed BCD dividend by a packed BCD divisor without any subtraction in its main loop. It forms the divisor's deficit from the next power of ten, which is ten to the power of the divisor's digit count. It then walks the dividend's columns from the most significant one. Each column that belongs to the quotient field is multiplied by the deficit digits and added into the columns to its right. When all quotient columns have been processed, the quotient field and the remainder field each hold a weighted sum whose column values may exceed nine. These sums are turned into proper BCD digits by a carry pass over each field. A final correction loop removes any excess in the remainder by subtracting the divisor and counting each subtraction into the quotient.

The method is fastest when the divisor lies just below a power of ten, because the deficit is then small and few corrections are needed. Any nonzero divisor gives the exact result; only the number of correction cycles grows. A host places operands on the inputs and pulses `start`. It then waits for a one-cycle `done`, at which point the quotient, the remainder and the zero-divisor flag are valid. They hold until the next `done`.

Top module: `deficit_divider`

## Requirements
- R1: A start with an all-zero divisor is answered on the next clock edge: `done` and `div_err` are both high, and the quotient and remainder read zero.
- R2: For a nonzero divisor, when `done` rises the quotient equals floor(dividend / divisor) and the remainder equals dividend mod divisor. Both inputs and outputs are packed BCD with the least significant digit in bits [3:0], digit i in bits [4i+3:4i].
- R3: Whenever `done` is high without `div_err`, the remainder is strictly smaller than the divisor of the accepted operation.
- R4: `done` is high for exactly one clock per accepted operation.
- R5: A `start` pulse that arrives while an operation is in progress is ignored. The running result is unchanged, and no further `done` follows it.
- R6: `div_err` is low after any division by a nonzero divisor, including one that directly follows a division by zero.
- R7: Quotient, remainder and `div_err` change only in the cycle where `done` is high, and otherwise hold even when the operand inputs change.
- R8: A dividend smaller than the divisor yields quotient zero and the dividend itself as remainder.
- R9: A divisor whose last digit is zero, whose deficit therefore carries out of its last digit, divides correctly.
- R10: After reset, `done` and `div_err` are low and the quotient and remainder read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division with the present operands when idle |
| dividend | input | 4*P | Dividend, P packed BCD digits |
| divisor | input | 4*K | Divisor, K packed BCD digits |
| quotient | output | 4*P | Quotient, P packed BCD digits |
| remainder | output | 4*K | Remainder, K packed BCD digits |
| done | output | 1 | One-cycle pulse when results are valid |
| div_err | output | 1 | Set with `done` when the divisor was zero |

## Verification
The bench builds the block with six dividend digits and two divisor digits. This gives a quotient field of four columns and a remainder field of two. With that split, column sums climb well past nine, the carry pass has to ripple several decimal digits out of both fields, and the quotient can need more digits than its field has columns. Divisors from 50 to 99 are drawn at random. Their deficits range from one to fifty, so the runs cover cases that need no correction at all and cases that need over a thousand corrections. Directed cases add divisors ending in zero, single-digit divisors, dividends below the divisor and a start pulse issued while the block is busy.

// File: rtl/dd_pkg.sv
package dd_pkg;

    typedef logic [3:0] digit_t;

    typedef struct packed {
        logic   cy;
        digit_t d;
    } digit_res_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_NORM_R,
        ST_NORM_Q,
        ST_CORR
    } dd_state_e;

    function automatic digit_t nines_of(input digit_t a);
        return 4'd9 - a;
    endfunction

    function automatic digit_res_t bcd_inc_digit(input digit_t a, input logic cin);
        digit_res_t r;
        logic [4:0] t;
        t = {1'b0, a} + {4'b0, cin};
        if (t >= 5'd10) begin
            r.d  = digit_t'(t - 5'd10);
            r.cy = 1'b1;
        end else begin
            r.d  = t[3:0];
            r.cy = 1'b0;
        end
        return r;
    endfunction

    function automatic digit_res_t bcd_sub_digit(input digit_t a, input digit_t b, input logic bin);
        digit_res_t r;
        logic [4:0] t;
        t = {1'b0, a} + 5'd10 - {1'b0, b} - {4'b0, bin};
        if (t >= 5'd10) begin
            r.d  = digit_t'(t - 5'd10);
            r.cy = 1'b0;
        end else begin
            r.d  = t[3:0];
            r.cy = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/dd_deficit.sv
module dd_deficit
    import dd_pkg::*;
#(
    parameter int K = 2
) (
    input  logic [4*K-1:0] divisor,
    output logic [4*K-1:0] deficit
);
    digit_res_t stage [K];
    logic       cin   [K];
    logic       unused_top_carry;

    assign cin[0] = 1'b1;

    for (genvar i = 0; i < K; i++) begin : g_dig
        assign stage[i] = bcd_inc_digit(nines_of(divisor[4*i +: 4]), cin[i]);
        assign deficit[4*i +: 4] = stage[i].d;
        if (i < K - 1) begin : g_chain
            assign cin[i+1] = stage[i].cy;
        end
    end

    assign unused_top_carry = stage[K-1].cy;
endmodule

// File: rtl/dd_columns.sv
module dd_columns #(
    parameter int P  = 6,
    parameter int K  = 2,
    parameter int CW = 28,
    parameter int IW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [4*P-1:0]  dividend,
    input  logic            step,
    input  logic [IW-1:0]   step_idx,
    input  logic [4*K-1:0]  deficit,
    input  logic [IW-1:0]   rd_idx,
    output logic [CW-1:0]   col_rd
);
    logic [CW-1:0] cols   [P];
    logic [CW-1:0] addend [P];
    logic [CW-1:0] src;

    always_comb begin
        src    = '0;
        col_rd = '0;
        for (int c = 0; c < P; c++) begin
            if (step_idx == IW'(c)) src    = cols[c];
            if (rd_idx   == IW'(c)) col_rd = cols[c];
        end
    end

    always_comb begin
        for (int c = 0; c < P; c++) begin
            addend[c] = '0;
            for (int j = 0; j < K; j++) begin
                if (int'(step_idx) + j + 1 == c)
                    addend[c] = src * CW'(deficit[4*(K-1-j) +: 4]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < P; c++) cols[c] <= '0;
        end else if (load) begin
            for (int c = 0; c < P; c++) cols[c] <= CW'(dividend[4*(P-1-c) +: 4]);
        end else if (step) begin
            for (int c = 0; c < P; c++) cols[c] <= cols[c] + addend[c];
        end
    end
endmodule

// File: rtl/dd_settle.sv
module dd_settle
    import dd_pkg::*;
#(
    parameter int P  = 6,
    parameter int K  = 2,
    parameter int CW = 28,
    parameter int IW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            norm_en,
    input  logic            norm_sel,
    input  logic            norm_first,
    input  logic [IW-1:0]   norm_pos,
    input  logic [CW-1:0]   norm_val,
    input  logic            corr_en,
    input  logic [4*K-1:0]  divisor,
    output logic [4*P-1:0]  quot_bcd,
    output logic [4*K-1:0]  rem_bcd,
    output logic            rem_ge
);
    localparam int PADW = 4 * (P - K);

    digit_t        qd [P];
    digit_t        rd [P];
    logic [CW-1:0] carry_q;
    logic [CW-1:0] sum;
    digit_t        nd;
    logic [4*P-1:0] rd_flat;
    logic [4*P-1:0] div_ext;
    digit_res_t    sub_r [P];
    digit_res_t    inc_r [P];
    logic          bw    [P];
    logic          ic    [P];
    logic          unused_chain_out;

    assign sum     = norm_val + (norm_first ? '0 : carry_q);
    assign nd      = digit_t'(sum % CW'(10));
    assign div_ext = {{PADW{1'b0}}, divisor};
    assign bw[0]   = 1'b0;
    assign ic[0]   = 1'b1;

    for (genvar i = 0; i < P; i++) begin : g_dig
        assign rd_flat[4*i +: 4]  = rd[i];
        assign quot_bcd[4*i +: 4] = qd[i];
        assign sub_r[i] = bcd_sub_digit(rd[i], div_ext[4*i +: 4], bw[i]);
        assign inc_r[i] = bcd_inc_digit(qd[i], ic[i]);
        if (i < P - 1) begin : g_chain
            assign bw[i+1] = sub_r[i].cy;
            assign ic[i+1] = inc_r[i].cy;
        end
    end

    assign unused_chain_out = sub_r[P-1].cy ^ inc_r[P-1].cy;
    assign rem_ge  = rd_flat >= div_ext;
    assign rem_bcd = rd_flat[4*K-1:0];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            carry_q <= '0;
            for (int i = 0; i < P; i++) begin
                qd[i] <= '0;
                rd[i] <= '0;
            end
        end else if (norm_en) begin
            carry_q <= sum / CW'(10);
            for (int i = 0; i < P; i++) begin
                if (norm_pos == IW'(i)) begin
                    if (norm_sel) qd[i] <= nd;
                    else          rd[i] <= nd;
                end
            end
        end else if (corr_en && rem_ge) begin
            for (int i = 0; i < P; i++) begin
                rd[i] <= sub_r[i].d;
                qd[i] <= inc_r[i].d;
            end
        end
    end
endmodule

// File: rtl/deficit_divider.sv
module deficit_divider
    import dd_pkg::*;
#(
    parameter int P = 6,
    parameter int K = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [4*P-1:0]  dividend,
    input  logic [4*K-1:0]  divisor,
    output logic [4*P-1:0]  quotient,
    output logic [4*K-1:0]  remainder,
    output logic            done,
    output logic            div_err
);
    localparam int Q  = P - K;
    localparam int CW = 4 * P + 4;
    localparam int IW = $clog2(P + 1);

    dd_state_e      state;
    logic [IW-1:0]  cnt;
    logic [4*K-1:0] div_q;
    logic [4*K-1:0] deficit;
    logic           busy;
    logic           load;
    logic [IW-1:0]  rd_idx;
    logic [CW-1:0]  col_rd;
    logic [CW-1:0]  norm_val;
    logic           col_ok;
    logic [4*P-1:0] qd_bcd;
    logic [4*K-1:0] rd_bcd;
    logic           rem_ge;

    assign busy = (state != ST_IDLE);
    assign load = (state == ST_IDLE) && start && (divisor != '0);

    always_comb begin
        rd_idx = '0;
        col_ok = 1'b0;
        if (state == ST_NORM_R) begin
            rd_idx = IW'(P - 1) - cnt;
            col_ok = (cnt < IW'(K));
        end else if (state == ST_NORM_Q) begin
            rd_idx = IW'(Q - 1) - cnt;
            col_ok = (cnt < IW'(Q));
        end
    end
    assign norm_val = col_ok ? col_rd : '0;

    dd_deficit #(.K(K)) u_deficit (
        .divisor (div_q),
        .deficit (deficit)
    );

    dd_columns #(.P(P), .K(K), .CW(CW), .IW(IW)) u_columns (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .dividend (dividend),
        .step     (state == ST_ACCUM),
        .step_idx (cnt),
        .deficit  (deficit),
        .rd_idx   (rd_idx),
        .col_rd   (col_rd)
    );

    dd_settle #(.P(P), .K(K), .CW(CW), .IW(IW)) u_settle (
        .clk        (clk),
        .rst        (rst),
        .clear      (load),
        .norm_en    ((state == ST_NORM_R) || (state == ST_NORM_Q)),
        .norm_sel   (state == ST_NORM_Q),
        .norm_first (cnt == '0),
        .norm_pos   (cnt),
        .norm_val   (norm_val),
        .corr_en    (state == ST_CORR),
        .divisor    (div_q),
        .quot_bcd   (qd_bcd),
        .rem_bcd    (rd_bcd),
        .rem_ge     (rem_ge)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            div_q     <= '0;
            quotient  <= '0;
            remainder <= '0;
            done      <= 1'b0;
            div_err   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (divisor == '0) begin
                            done      <= 1'b1;
                            div_err   <= 1'b1;
                            quotient  <= '0;
                            remainder <= '0;
                        end else begin
                            div_q <= divisor;
                            cnt   <= '0;
                            state <= ST_ACCUM;
                        end
                    end
                end
                ST_ACCUM: begin
                    if (cnt == IW'(Q - 1)) begin
                        cnt   <= '0;
                        state <= ST_NORM_R;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_NORM_R: begin
                    if (cnt == IW'(P - 1)) begin
                        cnt   <= '0;
                        state <= ST_NORM_Q;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_NORM_Q: begin
                    if (cnt == IW'(P - 1)) begin
                        cnt   <= '0;
                        state <= ST_CORR;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CORR: begin
                    if (!rem_ge) begin
                        done      <= 1'b1;
                        div_err   <= 1'b0;
                        quotient  <= qd_bcd;
                        remainder <= rd_bcd;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dd_checker.sv
module dd_checker #(
    parameter int P = 6,
    parameter int K = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic [4*K-1:0] divisor,
    input logic [4*P-1:0] quotient,
    input logic [4*K-1:0] remainder,
    input logic           done,
    input logic           div_err
);
    logic [4*K-1:0] div_seen;

    always_ff @(posedge clk) begin
        if (rst)                 div_seen <= '0;
        else if (start && !busy) div_seen <= divisor;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4

    AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
        (done && !div_err) |-> (remainder < div_seen)); // R3

    AST_ZERO_DIV_FLAG: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor == '0) |=> (done && div_err)); // R1

    AST_ERR_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        (done && div_err) |-> (quotient == '0 && remainder == '0)); // R1

    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_err))); // R7

    AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !(done && div_err)); // R5
endmodule

bind deficit_divider dd_checker #(.P(P), .K(K)) u_dd_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .done      (done),
    .div_err   (div_err)
);

// File: tb/test_deficit_divider.sv
`timescale 1ns/100ps
module test_deficit_divider;
    localparam int P = 6;
    localparam int K = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [4*P-1:0] dividend = '0;
    logic [4*K-1:0] divisor = '0;
    logic [4*P-1:0] quotient;
    logic [4*K-1:0] remainder;
    logic           done;
    logic           div_err;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    deficit_divider #(.P(P), .K(K)) i_deficit_divider (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .remainder(remainder), .done(done), .div_err(div_err)
    );

    function automatic logic [4*P-1:0] to_bcd(input int n);
        logic [4*P-1:0] b;
        int v;
        v = n;
        for (int i = 0; i < P; i++) begin
            b[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return b;
    endfunction

    function automatic int from_bcd(input logic [4*P-1:0] b);
        int v;
        v = 0;
        for (int i = P - 1; i >= 0; i--) v = v * 10 + int'(b[4*i +: 4]);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d, expected %0d", req, got, exp);
        end
    endtask

    task automatic put_ops(input int n, input int v);
        logic [4*P-1:0] vb;
        vb = to_bcd(v);
        dividend = to_bcd(n);
        divisor  = vb[4*K-1:0];
    endtask

    task automatic wait_done(output bit seen);
        int w;
        w = 0;
        while (!done && w < 20000) begin
            @(negedge clk);
            w++;
        end
        seen = done;
    endtask

    task automatic run_div(input int n, input int v, input string req);
        bit seen;
        int eq, er;
        logic [4*P-1:0] rb;
        @(negedge clk);
        put_ops(n, v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        check(seen, {req, " done"}, int'(seen), 1);
        if (v == 0) begin
            eq = 0; er = 0;
        end else begin
            eq = n / v; er = n % v;
        end
        rb = '0;
        rb[4*K-1:0] = remainder;
        check(div_err == (v == 0), {req, " div_err"}, int'(div_err), int'(v == 0));
        check(from_bcd(quotient) == eq, {req, " quotient"}, from_bcd(quotient), eq);
        check(from_bcd(rb) == er, {req, " remainder"}, from_bcd(rb), er);
        @(negedge clk);
        check(!done, "R4 done pulse width", int'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        bit seen;
        int cnt_done;
        logic [4*P-1:0] q_hold;
        logic [4*K-1:0] r_hold;
        void'($urandom(32'd7321));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!done, "R10 done", int'(done), 0);
        check(!div_err, "R10 div_err", int'(div_err), 0);
        check(quotient == '0, "R10 quotient", from_bcd(quotient), 0);
        check(remainder == '0, "R10 remainder", int'(remainder), 0);

        // R1 zero divisor answered on next edge
        @(negedge clk);
        put_ops(123456, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && div_err, "R1 immediate error", int'({done, div_err}), 3);
        check(quotient == '0 && remainder == '0, "R1 zeroed outputs", from_bcd(quotient), 0);
        @(negedge clk);

        // R6 error clears on next valid division
        run_div(999999, 99, "R6");
        run_div(999999, 91, "R2 correction-heavy");
        run_div(999999, 90, "R9 trailing zero divisor");
        run_div(123450, 60, "R9 trailing zero divisor");
        run_div(42, 97, "R8 small dividend");
        run_div(0, 95, "R8 zero dividend");
        run_div(98, 99, "R8 dividend one below divisor");
        run_div(99, 99, "R2 dividend equals divisor");
        run_div(50, 7, "R2 single digit divisor");
        run_div(123, 1, "R2 unit divisor");
        run_div(999999, 50, "R2 large deficit");
        run_div(0, 0, "R1 zero over zero");
        run_div(500000, 99, "R6 after error");

        // R5 start while busy is ignored
        @(negedge clk);
        put_ops(987654, 93);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        put_ops(111111, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        check(seen && !div_err, "R5 running op finished without error", int'(div_err), 0);
        check(from_bcd(quotient) == 987654 / 93, "R5 quotient kept", from_bcd(quotient), 987654 / 93);
        check(int'(remainder[7:4]) * 10 + int'(remainder[3:0]) == 987654 % 93,
              "R5 remainder kept", int'(remainder[7:4]) * 10 + int'(remainder[3:0]), 987654 % 93);
        cnt_done = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done) cnt_done++;
        end
        check(cnt_done == 0, "R5 no extra done", cnt_done, 0);

        // R7 outputs hold while inputs change
        q_hold = quotient;
        r_hold = remainder;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            put_ops(int'($urandom % 1000000), 50 + int'($urandom % 50));
        end
        check(quotient == q_hold && remainder == r_hold && !div_err, "R7 hold",
              from_bcd(quotient), from_bcd(q_hold));

        // R2 random divisors just below one hundred
        for (int i = 0; i < 40; i++) begin
            run_div(int'($urandom % 1000000), 50 + int'($urandom % 50), "R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule